// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends words over a two-wire clocked serial link. The block drives both the shift clock and the data line. A host writes each word into a single holding register. When the shifter is free, the word moves into a shift register in one system clock. The shift register then sends the bits least significant first, at a rate set by a programmable divisor. If the host refills the holding register before the last bit of the current word has left, the next word follows with no idle gap on the line.

The block has three outputs for the host:
- A buffer-empty flag. It sets when the holding register hands its word to the shifter and clears only when the host writes again. Gated with an enable, it drives an interrupt line.
- A shifter-empty status that the host polls. No interrupt is tied to it.
- A receive-inhibit output that keeps the half-duplex link one-way while words are pending or going out.

The idle level of the clock and the idle level of the data line are each selected on their own. An optional ninth bit is captured with each word.

Top module: `sms_tx`

## Requirements
- R1: The block shifts only while `port_en_i`, `sync_en_i`, `master_en_i` and `tx_en_i` are all high. If any of them is low, the shifter is empty one cycle later and the word in progress is abandoned. A word already in the holding register stays there and is sent once all four enables are high again.
- R2: `rx_inhibit_o` is high whenever the shifter holds a word. It is also high when a word waits in the holding register while the block is enabled.
- R3: `clk_inv_i` = 1 makes the shift clock idle high. `clk_inv_i` = 0 makes it idle low.
- R4: `dat_inv_i` = 1 makes the data line idle high and inverts every transmitted bit. `dat_inv_i` = 0 makes it idle low and sends bits unchanged.
- R5: Each bit period lasts 2×(D+1) system clocks, where D is the effective divisor. The clock is at its active level for the first D+1 clocks and back at its idle level for the last D+1. The data line changes only when the clock leaves idle, and it is stable while the clock is active.
- R6: A word in the holding register is moved to the shifter in the same cycle that the last bit of the previous word ends. Consecutive words therefore keep the same bit period across the word boundary.
- R7: If the shifter is empty and the block is enabled, a written word is loaded on the clock edge after the write. On that edge `buf_empty_o` sets, `shift_empty_o` clears and the clock leaves idle carrying bit 0.
- R8: `buf_empty_o` is 1 after reset and clears only on a write (`wr_i` high for one cycle). A write while the holding register is full replaces its contents, keeps the flag clear, and only the last written word is sent.
- R9: `irq_o` is high exactly when `buf_empty_o` and `irq_en_i` are both high. The flag itself sets whatever the value of `irq_en_i`.
- R10: `shift_empty_o` is 1 after reset and whenever no word is being shifted. While it is 1, both lines are at their idle levels.
- R11: With `nine_bit_i` = 1 at load time, a word is 9 bits long. Its last bit is the `ninth_i` value sampled on the write cycle, not its later value.
- R12: Bits leave least significant first.
- R13: The effective divisor D is the full 16-bit `div_i` when `wide_div_i` = 1. When `wide_div_i` = 0 it is `div_i[7:0]` alone. D = 0 gives a 2-clock bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| sync_en_i | input | 1 | Synchronous mode enable |
| master_en_i | input | 1 | Master clock source enable |
| tx_en_i | input | 1 | Transmit enable |
| clk_inv_i | input | 1 | Shift clock idle level |
| dat_inv_i | input | 1 | Data idle level and bit inversion |
| nine_bit_i | input | 1 | 9-bit word mode |
| ninth_i | input | 1 | Ninth bit, captured on write |
| wide_div_i | input | 1 | Use the 16-bit divisor |
| div_i | input | 16 | Baud divisor |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Write data |
| irq_en_i | input | 1 | Interrupt enable |
| buf_empty_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Interrupt request |
| shift_empty_o | output | 1 | Shift register empty status |
| rx_inhibit_o | output | 1 | Receive path inhibit |
| sclk_o | output | 1 | Shift clock line |
| sdat_o | output | 1 | Data line |

## Verification
The assertions check the following on every cycle:
- The lines rest at their idle levels whenever the shifter is empty.
- Dropping an enable empties the shifter.
- Data never moves while the clock is active.
- The buffer flag falls only after a write.
- The flag rises only on a load that fills the shifter.
- Receive stays inhibited while a word is out.

Only the directed scenarios can show the rest:
- The bit order and the bit values.
- The ninth bit being captured on the write cycle.
- The exact bit-period length for both divisor widths.
- The gap-free joining of consecutive words.
- Overwrite semantics.
- The one-cycle load latency.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 16;

  typedef enum logic {
    PH_ACT = 1'b0,  // clock at active level, bit just launched
    PH_IDL = 1'b1   // clock back at idle, receiver has sampled
  } phase_e;
endpackage

// File: rtl/sms_baud.sv
module sms_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wide_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_done_o
);
  localparam int unsigned NARROW_W = DIV_W / 2;

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt_q;

  assign eff_div     = wide_i ? div_i : {{(DIV_W-NARROW_W){1'b0}}, div_i[NARROW_W-1:0]};
  assign half_done_o = run_i && (cnt_q == eff_div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || half_done_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sms_hold.sv
module sms_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      // a write beats a same-cycle take: old word goes out, new one stays
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sms_shift.sv
module sms_shift
  import sms_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        nine_i,
  input  logic        half_done_i,
  input  logic        hold_full_i,
  input  logic [DW:0] hold_data_i,
  output logic        take_o,
  output logic        busy_o,
  output logic        clk_act_o,
  output logic        bit_o
);
  localparam int unsigned IDX_W = $clog2(DW + 1);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(DW - 1);
  localparam logic [IDX_W-1:0] LAST9 = IDX_W'(DW);

  logic [DW:0]      sreg_q;
  logic [IDX_W-1:0] idx_q;
  logic             nine_q;
  phase_e           phase_q;
  logic             last_bit;
  logic             end_of_bit;

  assign last_bit   = (idx_q == (nine_q ? LAST9 : LAST8));
  assign end_of_bit = busy_o && (phase_q == PH_IDL) && half_done_i;
  assign take_o     = en_i && hold_full_i && (!busy_o || (end_of_bit && last_bit));
  assign clk_act_o  = busy_o && (phase_q == PH_ACT);
  assign bit_o      = busy_o && sreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      idx_q   <= '0;
      nine_q  <= 1'b0;
      phase_q <= PH_ACT;
      busy_o  <= 1'b0;
    end else if (!en_i) begin
      idx_q   <= '0;
      phase_q <= PH_ACT;
      busy_o  <= 1'b0;
    end else if (take_o) begin
      sreg_q  <= hold_data_i;
      nine_q  <= nine_i;
      idx_q   <= '0;
      phase_q <= PH_ACT;
      busy_o  <= 1'b1;
    end else if (busy_o && half_done_i) begin
      if (phase_q == PH_ACT) begin
        phase_q <= PH_IDL;
      end else if (last_bit) begin
        busy_o  <= 1'b0;
        phase_q <= PH_ACT;
      end else begin
        idx_q   <= idx_q + 1'b1;
        sreg_q  <= {1'b0, sreg_q[DW:1]};
        phase_q <= PH_ACT;
      end
    end
  end
endmodule

// File: rtl/sms_tx.sv
module sms_tx
  import sms_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned DVW  = DIV_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           port_en_i,
  input  logic           sync_en_i,
  input  logic           master_en_i,
  input  logic           tx_en_i,
  input  logic           clk_inv_i,
  input  logic           dat_inv_i,
  input  logic           nine_bit_i,
  input  logic           ninth_i,
  input  logic           wide_div_i,
  input  logic [DVW-1:0] div_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           irq_en_i,
  output logic           buf_empty_o,
  output logic           irq_o,
  output logic           shift_empty_o,
  output logic           rx_inhibit_o,
  output logic           sclk_o,
  output logic           sdat_o
);
  logic          active;
  logic          hold_full;
  logic [DW:0]   hold_data;
  logic          take;
  logic          busy;
  logic          clk_act;
  logic          tx_bit;
  logic          half_done;

  assign active = port_en_i && sync_en_i && master_en_i && tx_en_i;

  sms_hold #(.W(DW + 1)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i ({ninth_i, wr_data_i}),
    .take_i    (take),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  sms_baud #(.DIV_W(DVW)) u_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy),
    .wide_i      (wide_div_i),
    .div_i       (div_i),
    .half_done_o (half_done)
  );

  sms_shift #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (active),
    .nine_i      (nine_bit_i),
    .half_done_i (half_done),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .busy_o      (busy),
    .clk_act_o   (clk_act),
    .bit_o       (tx_bit)
  );

  assign buf_empty_o   = !hold_full;
  assign irq_o         = buf_empty_o && irq_en_i;
  assign shift_empty_o = !busy;
  assign rx_inhibit_o  = busy || (hold_full && active);
  assign sclk_o        = clk_inv_i ^ clk_act;
  assign sdat_o        = dat_inv_i ^ tx_bit;
endmodule

// File: rtl/sms_tx_chk.sv
module sms_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic sync_en_i,
  input logic master_en_i,
  input logic tx_en_i,
  input logic clk_inv_i,
  input logic dat_inv_i,
  input logic wr_i,
  input logic buf_empty_o,
  input logic shift_empty_o,
  input logic rx_inhibit_o,
  input logic sclk_o,
  input logic sdat_o
);
  a_r1_off_empties_shifter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_en_i && sync_en_i && master_en_i && tx_en_i) |=> shift_empty_o);

  a_r10_empty_lines_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> (sclk_o == clk_inv_i) && (sdat_o == dat_inv_i));

  a_r5_data_stable_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_empty_o && $past(!shift_empty_o) && (sclk_o != clk_inv_i)
     && ($past(sclk_o) != $past(clk_inv_i)) && $stable(dat_inv_i)) |-> $stable(sdat_o));

  a_r8_flag_clears_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_empty_o) |-> $past(wr_i));

  a_r7_flag_sets_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !shift_empty_o);

  a_r2_inhibit_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_empty_o |-> rx_inhibit_o);
endmodule

bind sms_tx sms_tx_chk u_chk (.*);

// File: tb/sim_sms_tx.sv
`timescale 1ns/1ps
module sim_sms_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, sync_en = 0, master_en = 0, tx_en = 0;
  logic clk_inv = 0, dat_inv = 0, nine_bit = 0, ninth = 0, wide_div = 0;
  logic [15:0] div = '0;
  logic wr = 0;
  logic [7:0] wr_data = '0;
  logic irq_en = 0;
  logic buf_empty, irq, shift_empty, rx_inh, sclk, sdat;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sms_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .sync_en_i(sync_en),
    .master_en_i(master_en), .tx_en_i(tx_en), .clk_inv_i(clk_inv), .dat_inv_i(dat_inv),
    .nine_bit_i(nine_bit), .ninth_i(ninth), .wide_div_i(wide_div), .div_i(div),
    .wr_i(wr), .wr_data_i(wr_data), .irq_en_i(irq_en), .buf_empty_o(buf_empty),
    .irq_o(irq), .shift_empty_o(shift_empty), .rx_inhibit_o(rx_inh),
    .sclk_o(sclk), .sdat_o(sdat)
  );

  // line monitor: captures bits when the clock returns to idle
  logic cap [0:63];
  int cap_n = 0;
  logic prev_sclk = 1'b0;
  int last_lead = 0;
  logic lead_valid = 1'b0;
  int iv_min = 0, iv_max = 0, act_bad = 0, exp_half = 1;

  always @(negedge clk) begin
    if (prev_sclk == clk_inv && sclk != clk_inv) begin
      if (lead_valid) begin
        if (iv_min == 0 || cyc - last_lead < iv_min) iv_min = cyc - last_lead;
        if (cyc - last_lead > iv_max) iv_max = cyc - last_lead;
      end
      last_lead = cyc;
      lead_valid = 1'b1;
    end else if (prev_sclk != clk_inv && sclk == clk_inv) begin
      if (cyc - last_lead != exp_half) act_bad = act_bad + 1;
      if (cap_n < 64) cap[cap_n] = sdat ^ dat_inv;
      cap_n = cap_n + 1;
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle_and_clear(input int half);
    @(negedge clk); @(negedge clk);
    cap_n = 0; lead_valid = 1'b0; iv_min = 0; iv_max = 0; act_bad = 0; exp_half = half;
  endtask

  task automatic write_word(input logic [7:0] d, input logic n9);
    @(negedge clk);
    wr = 1'b1; wr_data = d; ninth = n9;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!(shift_empty && buf_empty) && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic check_bits(input int base, input logic [8:0] w, input int nb, input string req);
    int errs = 0;
    for (int i = 0; i < nb; i++) if (cap[base + i] !== w[i]) errs++;
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic enable_all(input logic on);
    port_en = on; sync_en = on; master_en = on; tx_en = on;
  endtask

  task automatic t_reset();
    chk(buf_empty === 1'b1, "R8 reset flag", buf_empty, 1);
    chk(shift_empty === 1'b1, "R10 reset status", shift_empty, 1);
    chk(sclk === 1'b0 && sdat === 1'b0, "R3 reset idle lines", {sclk, sdat}, 0);
    chk(irq === 1'b0 && rx_inh === 1'b0, "R9 reset irq", {irq, rx_inh}, 0);
  endtask

  task automatic t_basic();
    enable_all(1); div = 16'd0; wide_div = 0; clk_inv = 0; dat_inv = 0; nine_bit = 0;
    settle_and_clear(1);
    write_word(8'hA5, 1'b0);
    chk(buf_empty === 1'b0 && shift_empty === 1'b1, "R8 flag clears on write", buf_empty, 0);
    @(negedge clk);
    chk(buf_empty === 1'b1 && shift_empty === 1'b0 && sclk === 1'b1 && sdat === 1'b1,
        "R7 one-cycle load", {buf_empty, shift_empty, sclk, sdat}, 4'b1011);
    chk(rx_inh === 1'b1, "R2 inhibit during send", rx_inh, 1);
    wait_done();
    chk(cap_n == 8, "R12 bit count", cap_n, 8);
    check_bits(0, 9'h0A5, 8, "R12 lsb first A5");
    chk(iv_min == 2 && iv_max == 2 && act_bad == 0, "R13 zero divisor period", iv_max, 2);
    chk(rx_inh === 1'b0 && sclk === 1'b0 && sdat === 1'b0, "R10 idle after word", {rx_inh, sclk, sdat}, 0);
  endtask

  task automatic t_polarity();
    clk_inv = 1; dat_inv = 1; div = 16'd1;
    settle_and_clear(2);
    chk(sclk === 1'b1 && sdat === 1'b1, "R3 R4 inverted idle", {sclk, sdat}, 3);
    write_word(8'h3C, 1'b0);
    @(negedge clk);
    chk(sclk === 1'b0 && sdat === 1'b1, "R4 inverted bit0 on line", {sclk, sdat}, 1);
    wait_done();
    check_bits(0, 9'h03C, 8, "R4 inverted data 3C");
    chk(iv_min == 4 && iv_max == 4 && act_bad == 0, "R5 period div1", iv_max, 4);
    clk_inv = 0; dat_inv = 0;
  endtask

  task automatic t_nine();
    nine_bit = 1; div = 16'd0;
    settle_and_clear(1);
    write_word(8'h81, 1'b1);
    ninth = 1'b0;
    wait_done();
    chk(cap_n == 9, "R11 nine bits", cap_n, 9);
    check_bits(0, 9'h181, 9, "R11 ninth bit captured at write");
    nine_bit = 0;
  endtask

  task automatic t_stream();
    irq_en = 1; div = 16'd2;
    settle_and_clear(3);
    chk(irq === 1'b1, "R9 irq with empty flag", irq, 1);
    write_word(8'h5A, 1'b0);
    chk(irq === 1'b0, "R9 irq clears on write", irq, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R9 irq on load", irq, 1);
    write_word(8'hC3, 1'b0);
    chk(buf_empty === 1'b0 && shift_empty === 1'b0, "R6 second word held", buf_empty, 0);
    wait_done();
    chk(cap_n == 16, "R6 both words sent", cap_n, 16);
    check_bits(0, 9'h05A, 8, "R6 first word");
    check_bits(8, 9'h0C3, 8, "R6 second word");
    chk(iv_min == 6 && iv_max == 6 && act_bad == 0, "R6 no gap between words", iv_max, 6);
    irq_en = 0;
    @(negedge clk);
    chk(irq === 1'b0 && buf_empty === 1'b1, "R9 flag without enable", {irq, buf_empty}, 1);
  endtask

  task automatic t_overwrite();
    tx_en = 0; div = 16'd0;
    settle_and_clear(1);
    write_word(8'h11, 1'b0);
    write_word(8'h22, 1'b0);
    repeat (10) @(negedge clk);
    chk(buf_empty === 1'b0, "R8 overwrite keeps flag clear", buf_empty, 0);
    chk(shift_empty === 1'b1 && sclk === 1'b0 && sdat === 1'b0 && rx_inh === 1'b0,
        "R1 disabled lines idle", {shift_empty, sclk, sdat, rx_inh}, 8);
    tx_en = 1;
    wait_done();
    chk(cap_n == 8, "R8 only one word", cap_n, 8);
    check_bits(0, 9'h022, 8, "R8 last write sent");
  endtask

  task automatic t_abort();
    div = 16'd3;
    settle_and_clear(4);
    write_word(8'hFF, 1'b0);
    repeat (6) @(negedge clk);
    port_en = 0;
    @(negedge clk);
    chk(shift_empty === 1'b1 && sclk === 1'b0 && sdat === 1'b0, "R1 abort to idle",
        {shift_empty, sclk, sdat}, 4);
    port_en = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_div_width();
    div = 16'h0102; wide_div = 0;
    settle_and_clear(3);
    write_word(8'h96, 1'b0);
    wait_done();
    chk(iv_min == 6 && iv_max == 6 && act_bad == 0, "R13 narrow divisor uses low byte", iv_max, 6);
    check_bits(0, 9'h096, 8, "R13 narrow data");
    wide_div = 1;
    settle_and_clear(259);
    write_word(8'h69, 1'b0);
    wait_done();
    chk(iv_min == 518 && iv_max == 518 && act_bad == 0, "R13 wide divisor period", iv_max, 518);
    check_bits(0, 9'h069, 8, "R13 wide data");
    wide_div = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_polarity();
    t_nine();
    t_stream();
    t_overwrite();
    t_abort();
    t_div_width();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule